// File: doc/BRIEF.md
# Retriggerable One-Shot Pulse Generator

This block is a clocked, two-channel retriggerable monostable. Each channel
has a trigger that fires on a falling edge and one that fires on a rising
edge. Each channel also has an active-low clear and a pair of complementary
outputs. A per-channel 16-bit cycle count sets how long the output pulse
lasts. Every qualified trigger reloads that count. A steady stream of
triggers can therefore hold the output high for as long as it continues.

All trigger and clear inputs are treated as asynchronous. Each one passes
through a two-flop synchroniser. Edges are found by comparing synchronised
samples from consecutive cycles. The clear gates the outputs directly, so a
pulse stops in the same cycle the clear goes low. The clear then empties the
counter once it has been synchronised. Releasing the clear never starts a
pulse. The block has no data path, so all pins are plain control pins with
no handshake.

Top module: `retrig_oneshot`

## Requirements
- R1: For every channel, `q_n` is always the exact complement of `q`.
- R2: The channels are independent: stimulus on one channel's pins never changes the other channel's outputs.
- R3: A falling edge on `trig_fall_n` while `trig_rise` is high starts a pulse. `q` goes high just after the third rising clock edge that samples the new low level.
- R4: A rising edge on `trig_rise` while `trig_fall_n` is low starts a pulse, with the same three-edge latency as R3.
- R5: A falling edge on `trig_fall_n` while `trig_rise` is low, a rising edge on `trig_rise` while `trig_fall_n` is high, a rising edge on `trig_fall_n` and a falling edge on `trig_rise` all leave `q` unchanged.
- R6: With no retrigger, `q` stays high for exactly W clock cycles, where W is the channel's slice of `width_cfg` (bits [16*i+15:16*i] for channel i). W values of 0 and 1 give 2 cycles.
- R7: A qualified trigger that arrives while `q` is high restarts the full width from that trigger. Repeated retriggers keep `q` high without a gap.
- R8: The width is captured when a trigger is accepted. Changing `width_cfg` during a pulse affects only later triggers.
- R9: While `clear_n` is low, `q` is low and `q_n` is high at once, without waiting for a clock edge. A running pulse is cancelled and trigger edges are ignored.
- R10: A low-to-high transition on `clear_n` never starts a pulse, whatever the trigger levels are. A trigger edge sampled in the same cycle as the release is ignored.
- R11: While `rst_n` is low, every `q` is low and every `q_n` is high, and all channel state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| trig_fall_n | input | NUM_CH | Falling-edge trigger per channel, qualified while `trig_rise` is high |
| trig_rise | input | NUM_CH | Rising-edge trigger per channel, qualified while `trig_fall_n` is low |
| clear_n | input | NUM_CH | Active-low clear per channel; cancels the pulse and blocks triggers |
| width_cfg | input | NUM_CH*CNT_W | Pulse width in clock cycles, CNT_W bits per channel |
| q | output | NUM_CH | Pulse output, active high |
| q_n | output | NUM_CH | Complement of `q` |

## Verification
The assertions assume that each low period of `clear_n` lasts at least three clock cycles. That is long enough for the synchronised clear to empty the counter before the release. A shorter low period would be masked at the output but could leave the count running. They also assume that trigger levels are held for whole cycles, so the synchroniser sees every edge. The stimulus drives all inputs once per cycle, away from the clock edge. The random phase holds every clear for three to eight cycles, and the directed cases for clear release and same-cycle trigger stay within the same limits.

// File: rtl/retrig_oneshot_pkg.sv
`timescale 1ns/1ps
package retrig_oneshot_pkg;

  localparam int unsigned DEF_CNT_W = 16;
  localparam int unsigned DEF_MIN_W = 2;

  // One channel's asynchronous pins, carried together through sync and edge logic.
  typedef struct packed {
    logic fall_n;
    logic rise;
    logic clr_n;
  } os_pins_t;

endpackage

// File: rtl/os_sync.sv
`timescale 1ns/1ps
module os_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned BITS   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);

  logic [BITS-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) pipe[s] <= '0;
          else        pipe[s] <= pipe[s-1];
        end
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/os_edge_qual.sv
`timescale 1ns/1ps
module os_edge_qual
  import retrig_oneshot_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  os_pins_t now_s,
  output logic     fire,
  output logic     hold_clear
);

  os_pins_t prev_s;
  logic     fall_hit;
  logic     rise_hit;
  logic     clr_settled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_s <= '0;
    else        prev_s <= now_s;
  end

  // Falling trigger gated by high rise pin; rising trigger gated by low fall pin.
  assign fall_hit    = prev_s.fall_n & ~now_s.fall_n & now_s.rise;
  assign rise_hit    = ~prev_s.rise & now_s.rise & ~now_s.fall_n;
  // Clear must be high in both samples: a release cycle blocks any edge.
  assign clr_settled = now_s.clr_n & prev_s.clr_n;

  assign fire       = clr_settled & (fall_hit | rise_hit);
  assign hold_clear = ~now_s.clr_n;

endmodule

// File: rtl/os_timer.sv
`timescale 1ns/1ps
module os_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned MIN_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] width,
  output logic             active
);

  localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(MIN_W);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;

  assign load_val = (width < MIN_VAL) ? MIN_VAL : width;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (clear)          remain <= '0;
    else if (load)           remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

endmodule

// File: rtl/retrig_oneshot.sv
`timescale 1ns/1ps
module retrig_oneshot
  import retrig_oneshot_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned CNT_W       = DEF_CNT_W,
  parameter int unsigned MIN_W       = DEF_MIN_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       trig_fall_n,
  input  logic [NUM_CH-1:0]       trig_rise,
  input  logic [NUM_CH-1:0]       clear_n,
  input  logic [NUM_CH*CNT_W-1:0] width_cfg,
  output logic [NUM_CH-1:0]       q,
  output logic [NUM_CH-1:0]       q_n
);

  localparam int unsigned PIN_BITS = $bits(os_pins_t);

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      os_pins_t raw_pins;
      os_pins_t sync_pins;
      logic     fire;
      logic     hold_clear;
      logic     active;

      assign raw_pins = '{fall_n: trig_fall_n[ch], rise: trig_rise[ch], clr_n: clear_n[ch]};

      os_sync #(
        .STAGES (SYNC_STAGES),
        .BITS   (PIN_BITS)
      ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_pins),
        .q     (sync_pins)
      );

      os_edge_qual u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_s      (sync_pins),
        .fire       (fire),
        .hold_clear (hold_clear)
      );

      os_timer #(
        .CNT_W (CNT_W),
        .MIN_W (MIN_W)
      ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (hold_clear),
        .load   (fire),
        .width  (width_cfg[ch*CNT_W +: CNT_W]),
        .active (active)
      );

      // Raw clear masks the output at once; the synced clear empties the count later.
      assign q[ch]   = active & clear_n[ch];
      assign q_n[ch] = ~q[ch];
    end
  endgenerate

endmodule

// File: rtl/retrig_oneshot_chk.sv
`timescale 1ns/1ps
module retrig_oneshot_chk #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] clear_n,
  input logic [NUM_CH-1:0] q,
  input logic [NUM_CH-1:0] q_n
);

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      // R9: a low clear pin holds the outputs inactive
      p_clear_masks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_n[i] |-> (!q[i] && q_n[i]));

      // R10: the output is already low when the clear is released
      p_release_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clear_n[i]) |-> !q[i]);

      // R10: a pulse only begins after the clear was high in the synchroniser window
      p_start_needs_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q[i]) |-> ($past(clear_n[i], 3) && $past(clear_n[i], 4)));

      // R6: with clear high, a pulse lasts at least two cycles
      p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q[i]) && clear_n[i]) |-> $past(q[i], 2));

      // R11: system reset holds the outputs inactive
      p_sys_reset_r11: assert property (@(posedge clk)
        !rst_n |-> (!q[i] && q_n[i]));
    end
  endgenerate

endmodule

bind retrig_oneshot retrig_oneshot_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear_n (clear_n),
  .q       (q),
  .q_n     (q_n)
);

// File: tb/tb_retrig_oneshot.sv
`timescale 1ns/1ps
module tb_retrig_oneshot;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  tfn = 2'b11;
  logic [1:0]  tr  = 2'b00;
  logic [1:0]  cn  = 2'b11;
  logic [31:0] wc  = {16'd4, 16'd4};
  logic [1:0]  q;
  logic [1:0]  q_n;

  int    n_checks = 0;
  int    n_fail   = 0;
  string phase    = "R11";

  // Reference state per channel
  logic [3:0] ha [2];
  logic [3:0] hb [2];
  logic [3:0] hc [2];
  int         rem [2];

  always #4 clk = ~clk;

  retrig_oneshot dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_fall_n (tfn),
    .trig_rise   (tr),
    .clear_n     (cn),
    .width_cfg   (wc),
    .q           (q),
    .q_n         (q_n)
  );

  function automatic int clampw(input int w);
    return (w < 2) ? 2 : w;
  endfunction

  function automatic int width_of(input int c);
    return (c == 0) ? int'(wc[15:0]) : int'(wc[31:16]);
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: update the reference from the levels sampled at the edge, then compare.
  task automatic step();
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        ha[c] = '0; hb[c] = '0; hc[c] = '0; rem[c] = 0;
      end else begin
        ha[c] = {ha[c][2:0], tfn[c]};
        hb[c] = {hb[c][2:0], tr[c]};
        hc[c] = {hc[c][2:0], cn[c]};
        if (!hc[c][2])
          rem[c] = 0;
        else if (hc[c][3] && ((ha[c][3] && !ha[c][2] && hb[c][2]) ||
                              (!hb[c][3] && hb[c][2] && !ha[c][2])))
          rem[c] = clampw(width_of(c));
        else if (rem[c] > 0)
          rem[c] = rem[c] - 1;
      end
    end
    #1;
    for (int c = 0; c < 2; c++) begin
      logic e;
      e = rst_n && (rem[c] != 0) && cn[c];
      chk(phase, q[c], e, $sformatf("q[%0d]", c));
      chk("R1", q_n[c], ~e, $sformatf("q_n[%0d]", c));
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int c = 0; c < 2; c++) begin
      ha[c] = '0; hb[c] = '0; hc[c] = '0; rem[c] = 0;
    end

    // R11: outputs held inactive during reset
    phase = "R11";
    run(4);
    rst_n = 1'b1;
    run(6);

    // R3: falling trigger with rise pin high, width 5
    phase = "R3";
    wc[15:0] = 16'd5;
    tr[0] = 1'b1;
    run(4);
    tfn[0] = 1'b0;
    run(10);
    tfn[0] = 1'b1;           // R5: rising fall-pin is not a trigger
    run(6);

    // R4: rising trigger with fall pin low, width 3
    phase = "R4";
    wc[31:16] = 16'd3;
    tfn[1] = 1'b0;
    run(4);
    tr[1] = 1'b1;
    run(8);
    tr[1] = 1'b0;            // R5: falling rise-pin is not a trigger
    run(4);

    // R6: widths 0 and 1 clamp to 2 cycles
    phase = "R6";
    wc[31:16] = 16'd0;
    tr[1] = 1'b1;
    run(8);
    tr[1] = 1'b0;
    wc[31:16] = 16'd1;
    run(4);
    tr[1] = 1'b1;
    run(8);

    // R5: edges with the other pin at the wrong level
    phase = "R5";
    tr[0] = 1'b0;
    run(3);
    tfn[0] = 1'b0;
    run(8);
    tfn[0] = 1'b1;
    tr[1] = 1'b0;
    tfn[1] = 1'b1;
    run(3);
    tr[1] = 1'b1;
    run(8);

    // R2: ch0 pulses while ch1 holds still
    phase = "R2";
    tr[0] = 1'b1;
    wc[15:0] = 16'd7;
    run(3);
    tfn[0] = 1'b0;
    run(12);
    tfn[0] = 1'b1;
    run(3);

    // R7: retrigger every 4 cycles with width 6 keeps q high
    phase = "R7";
    wc[15:0] = 16'd6;
    for (int k = 0; k < 8; k++) begin
      tfn[0] = 1'b0;
      run(2);
      tfn[0] = 1'b1;
      run(2);
    end
    run(10);

    // R8: width change mid-pulse affects only the next trigger
    phase = "R8";
    wc[15:0] = 16'd9;
    tfn[0] = 1'b0;
    run(4);
    wc[15:0] = 16'd2;
    run(10);
    tfn[0] = 1'b1;
    run(2);
    tfn[0] = 1'b0;
    run(6);
    tfn[0] = 1'b1;
    run(2);

    // R9: clear cuts a running pulse at once and blocks triggers
    phase = "R9";
    wc[15:0] = 16'd20;
    tfn[0] = 1'b0;
    run(6);
    cn[0] = 1'b0;
    #1;
    chk("R9", q[0], 1'b0, "q[0] right after clear");
    chk("R9", q_n[0], 1'b1, "q_n[0] right after clear");
    run(3);
    tfn[0] = 1'b1;
    run(2);
    tfn[0] = 1'b0;
    run(4);
    cn[0] = 1'b1;
    run(8);

    // R10: trigger edge in the release cycle, then release with qualifying levels
    phase = "R10";
    tfn[0] = 1'b1;
    cn[0] = 1'b0;
    run(5);
    cn[0] = 1'b1;
    tfn[0] = 1'b0;
    run(8);
    cn[0] = 1'b0;
    run(4);
    cn[0] = 1'b1;
    run(8);

    // R11: reset in the middle of a pulse
    phase = "R11";
    tfn[0] = 1'b1;
    run(2);
    tfn[0] = 1'b0;
    run(5);
    rst_n = 1'b0;
    #1;
    chk("R11", q[0], 1'b0, "q[0] during reset");
    run(3);
    rst_n = 1'b1;
    run(4);

    // Random mix over both channels, clear lows held 3..8 cycles
    phase = "R7";
    begin
      int clr_left [2];
      clr_left[0] = 0;
      clr_left[1] = 0;
      for (int k = 0; k < 3000; k++) begin
        for (int c = 0; c < 2; c++) begin
          if (($urandom % 6) == 0) tfn[c] = ~tfn[c];
          if (($urandom % 6) == 0) tr[c]  = ~tr[c];
          if (($urandom % 40) == 0) begin
            if (c == 0) wc[15:0]  = 16'($urandom % 12);
            else        wc[31:16] = 16'($urandom % 12);
          end
          if (clr_left[c] > 0) begin
            clr_left[c]--;
            if (clr_left[c] == 0) cn[c] = 1'b1;
          end else if (($urandom % 64) == 0) begin
            cn[c] = 1'b0;
            clr_left[c] = 3 + int'($urandom % 6);
          end
        end
        step();
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule